// File: doc/BRIEF.md
# Bus command strobe sequencer

This block turns the status code that a processor places at the start of a bus cycle into the timed control strobes for that cycle: an active-low read command, an active-low write command, an active-low data-enable and a data-direction level. The block runs on a clock whose edges alternate between the two halves of each bus state. An internal phase register labels each edge as rising or falling. The first edge after reset is a rising edge. A cycle opens on a rising edge and has a status phase of one half-state. A command phase follows, and it lasts until the ready input ends the cycle.

The command strobe can be held back by a hold input. This input is sampled on falling edges only, starting with the falling edge that closes the status phase. A late-command mode bit is latched at the start of each cycle. With the bit clear, the command fires on the same falling edge at which the hold input is first seen released. With the bit set, the command fires one half-state later, on the next rising edge. Ready is sampled on rising edges during the command phase. Ready ends the cycle even if the command has not been issued yet. In that case no command appears, and data-enable and direction are still torn down exactly as in a normal cycle.

Top module: `bus_cmd_seq`

## Requirements
- R1: Synchronous reset drives both command outputs high, `data_en_n` high and `dir_tx` high, and labels the first edge after reset as rising.
- R2: While idle, a status code sampled on a rising edge starts a cycle: `2'b01` is a read and `2'b10` is a write. `2'b11` and `2'b00` start nothing. A status code seen on a falling edge, or during a cycle, is ignored. `dir_tx` takes the cycle direction on the starting edge.
- R3: `data_en_n` goes low on the falling edge that ends the status phase, one clock after the start.
- R4: `cmd_hold` is sampled on that falling edge and on every later falling edge until a low value is seen. While it is sampled high, no command is driven.
- R5: With the late-command bit clear, the command output goes low on the falling edge at which `cmd_hold` is sampled low.
- R6: With the late-command bit set, the command output goes low on the rising edge that follows the falling edge at which `cmd_hold` is sampled low. The bit is latched at the start of the cycle, and later changes to it have no effect on that cycle.
- R7: `rdy_n` is sampled only on rising edges of the command phase. While it is high, the cycle stays open with its outputs unchanged.
- R8: `rdy_n` low on a command-phase rising edge returns all outputs to inactive on that edge. If no command has been issued by then, including a late command due on that same edge, no command is issued in that cycle, and the teardown is the same as for a cycle that did issue a command.
- R9: `dir_tx` is low for a read and high for a write, and it stays stable while `data_en_n` is low.
- R10: At most one command output is low at a time, and a command is low only while `data_en_n` is low.
- R11: A new cycle can start on the next rising edge after the edge on which ready ended the previous cycle, which is two clocks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-state clock; edges alternate rising and falling |
| rst | input | 1 | Synchronous reset, active high |
| bus_stat | input | STAT_W | Cycle status code from the processor |
| cmd_hold | input | 1 | Command hold; high delays the command |
| rdy_n | input | 1 | Active-low ready that ends the cycle |
| late_cmd | input | 1 | Late-command mode bit, latched at cycle start |
| rd_n | output | 1 | Active-low read command |
| wr_n | output | 1 | Active-low write command |
| data_en_n | output | 1 | Active-low data-enable |
| dir_tx | output | 1 | Data direction: 1 transmit (write), 0 receive (read) |

## Verification
Every output is registered, so each result is due on the edge that samples its cause and can be seen one delta after that edge. Counting edges from the start edge k=0, the results fall due as follows. Data-enable is due at k=1. An early command is due at 1+2d, where d is the number of high hold samples, and a late command at 2+2d. Teardown is due at 2+2w, where w is the number of high ready samples. The bench drives inputs just after each rising clock edge. It compares all four outputs after every edge against values that it computes from these formulas, so an output that changes one edge early or late is reported. A mode flip after the start edge, and a status code repeated on the ready edge, check that the design ignores these inputs at those points.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [1:0] {
        CYC_NONE = 2'd0,
        CYC_RD   = 2'd1,
        CYC_WR   = 2'd2
    } cyc_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STAT = 2'd1,
        ST_CMD  = 2'd2
    } st_e;

    typedef struct packed {
        st_e  st;
        cyc_e cyc;
        logic late;
        logic pend;
        logic issued;
        logic den;
        logic dir_tx;
    } ctl_s;

    localparam ctl_s CTL_RESET = '{
        st:     ST_IDLE,
        cyc:    CYC_NONE,
        late:   1'b0,
        pend:   1'b0,
        issued: 1'b0,
        den:    1'b0,
        dir_tx: 1'b1
    };

endpackage

// File: rtl/bcs_decode.sv
module bcs_decode
    import bcs_pkg::*;
#(
    parameter int                STAT_W  = 2,
    parameter logic [STAT_W-1:0] RD_CODE = 2'b01,
    parameter logic [STAT_W-1:0] WR_CODE = 2'b10
) (
    input  logic [STAT_W-1:0] stat_i,
    output cyc_e              cyc_o
);

    always_comb begin
        if (stat_i == RD_CODE)      cyc_o = CYC_RD;
        else if (stat_i == WR_CODE) cyc_o = CYC_WR;
        else                        cyc_o = CYC_NONE;
    end

endmodule

// File: rtl/bcs_phase.sv
module bcs_phase (
    input  logic clk,
    input  logic rst,
    output logic fall_o
);

    logic ph_d, ph_q;

    always_comb begin
        ph_d = ~ph_q;
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= 1'b0;
        else     ph_q <= ph_d;
    end

    // high when the coming edge closes the first half of a bus state
    assign fall_o = ph_q;

endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
    import bcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fall_i,
    input  cyc_e cyc_i,
    input  logic hold_i,
    input  logic rdy_n_i,
    input  logic late_i,
    output ctl_s ctl_o
);

    ctl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (!fall_i && cyc_i != CYC_NONE) begin
                    ctl_d.st     = ST_STAT;
                    ctl_d.cyc    = cyc_i;
                    ctl_d.late   = late_i;
                    ctl_d.dir_tx = (cyc_i == CYC_WR);
                    ctl_d.pend   = 1'b0;
                    ctl_d.issued = 1'b0;
                end
            end
            ST_STAT: begin
                // falling edge closing the status phase: first hold sample
                ctl_d.st  = ST_CMD;
                ctl_d.den = 1'b1;
                if (!hold_i) begin
                    if (ctl_q.late) ctl_d.pend   = 1'b1;
                    else            ctl_d.issued = 1'b1;
                end
            end
            ST_CMD: begin
                if (!fall_i) begin
                    if (!rdy_n_i) begin
                        ctl_d = CTL_RESET;
                    end else if (ctl_q.pend) begin
                        ctl_d.pend   = 1'b0;
                        ctl_d.issued = 1'b1;
                    end
                end else if (!ctl_q.issued && !ctl_q.pend && !hold_i) begin
                    if (ctl_q.late) ctl_d.pend   = 1'b1;
                    else            ctl_d.issued = 1'b1;
                end
            end
            default: ctl_d = CTL_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_RESET;
        else     ctl_q <= ctl_d;
    end

    assign ctl_o = ctl_q;

endmodule

// File: rtl/bus_cmd_seq.sv
module bus_cmd_seq
    import bcs_pkg::*;
#(
    parameter int                STAT_W  = 2,
    parameter logic [STAT_W-1:0] RD_CODE = 2'b01,
    parameter logic [STAT_W-1:0] WR_CODE = 2'b10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] bus_stat,
    input  logic              cmd_hold,
    input  logic              rdy_n,
    input  logic              late_cmd,
    output logic              rd_n,
    output logic              wr_n,
    output logic              data_en_n,
    output logic              dir_tx
);

    logic fall_w;
    cyc_e cyc_w;
    ctl_s ctl_w;

    bcs_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .fall_o (fall_w)
    );

    bcs_decode #(
        .STAT_W  (STAT_W),
        .RD_CODE (RD_CODE),
        .WR_CODE (WR_CODE)
    ) u_decode (
        .stat_i (bus_stat),
        .cyc_o  (cyc_w)
    );

    bcs_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .fall_i  (fall_w),
        .cyc_i   (cyc_w),
        .hold_i  (cmd_hold),
        .rdy_n_i (rdy_n),
        .late_i  (late_cmd),
        .ctl_o   (ctl_w)
    );

    assign rd_n      = ~(ctl_w.issued && ctl_w.cyc == CYC_RD);
    assign wr_n      = ~(ctl_w.issued && ctl_w.cyc == CYC_WR);
    assign data_en_n = ~ctl_w.den;
    assign dir_tx    = ctl_w.dir_tx;

endmodule

// File: rtl/bcs_chk.sv
module bcs_chk (
    input logic clk,
    input logic rst,
    input logic fall,
    input logic rdy_n,
    input logic rd_n,
    input logic wr_n,
    input logic data_en_n,
    input logic dir_tx
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (rd_n && wr_n && data_en_n && dir_tx));

    assert_en_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(data_en_n) |-> !fall);

    assert_ready_end_R8: assert property (@(posedge clk) disable iff (rst)
        (!fall && !data_en_n && !rdy_n) |=> (rd_n && wr_n && data_en_n && dir_tx));

    assert_dir_read_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !dir_tx);

    assert_dir_write_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> dir_tx);

    assert_dir_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !data_en_n |=> (data_en_n || $stable(dir_tx)));

    assert_cmd_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    assert_cmd_needs_en_R10: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> !data_en_n);

endmodule

bind bus_cmd_seq bcs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .fall      (fall_w),
    .rdy_n     (rdy_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .data_en_n (data_en_n),
    .dir_tx    (dir_tx)
);

// File: tb/tb_bus_cmd_seq.sv
module tb_bus_cmd_seq;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       wr;
        logic       late;
        logic [3:0] d;
        logic [3:0] w;
    } vec_t;

    // direction, late mode, high hold samples, high ready samples
    localparam vec_t VECS [12] = '{
        '{1'b0, 1'b0, 4'd0, 4'd0},
        '{1'b1, 1'b0, 4'd0, 4'd0},
        '{1'b0, 1'b1, 4'd0, 4'd0},
        '{1'b1, 1'b1, 4'd0, 4'd1},
        '{1'b0, 1'b0, 4'd2, 4'd1},
        '{1'b0, 1'b0, 4'd1, 4'd1},
        '{1'b1, 1'b1, 4'd1, 4'd1},
        '{1'b1, 1'b1, 4'd2, 4'd4},
        '{1'b0, 1'b0, 4'd3, 4'd5},
        '{1'b1, 1'b0, 4'd0, 4'd3},
        '{1'b0, 1'b1, 4'd3, 4'd3},
        '{1'b1, 1'b0, 4'd5, 4'd2}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_stat = 2'b11;
    logic       cmd_hold = 1'b1;
    logic       rdy_n = 1'b1;
    logic       late_cmd = 1'b0;
    logic       rd_n, wr_n, data_en_n, dir_tx;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [3:0] IDLE_OUT = 4'b1111;

    bus_cmd_seq dut (
        .clk       (clk),
        .rst       (rst),
        .bus_stat  (bus_stat),
        .cmd_hold  (cmd_hold),
        .rdy_n     (rdy_n),
        .late_cmd  (late_cmd),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .data_en_n (data_en_n),
        .dir_tx    (dir_tx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {rd_n, wr_n, data_en_n, dir_tx};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {rd_n,wr_n,data_en_n,dir_tx} got %b expected %b", tag, act, exp);
        end
    endtask

    // One full cycle from the start edge k=0 to the falling edge after teardown.
    task automatic run_vec(input logic wr, input logic late, input int d, input int w);
        int         eend;
        int         start;
        logic [1:0] code;
        eend  = 2 + 2*w;
        start = late ? 2 + 2*d : 1 + 2*d;
        code  = wr ? 2'b10 : 2'b01;
        for (int k = 0; k <= eend + 1; k++) begin
            logic       issued;
            logic [3:0] exp;
            string      tag;
            // code repeated on the ready edge must be ignored (R11)
            bus_stat = (k == 0 || k == eend) ? code : 2'b11;
            late_cmd = (k == 0) ? late : !late;
            cmd_hold = (k < 1 + 2*d);
            rdy_n    = !(k == eend);
            step();
            issued = (k >= start && k < eend);
            exp = {!(issued && !wr), !(issued && wr), !(k >= 1 && k < eend), (k < eend) ? wr : 1'b1};
            if (k == 0)                          tag = "R2 start";
            else if (k >= eend)                  tag = (k == eend) ? "R8 teardown" : "R11 idle gap";
            else if (issued)                     tag = late ? "R6 late command" : "R5 early command";
            else if (k == 1)                     tag = "R3 enable";
            else if (k < (late ? 2+2*d : 1+2*d)) tag = "R4 hold";
            else                                 tag = "R7 wait";
            chk(tag, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        chk("R1 reset", IDLE_OUT);
        rst = 1'b0;

        for (int i = 0; i < 12; i++) begin
            run_vec(VECS[i].wr, VECS[i].late, int'(VECS[i].d), int'(VECS[i].w));
        end

        // R2: idle codes start nothing
        bus_stat = 2'b11; step(); chk("R2 code 11 rising", IDLE_OUT);
        step(); chk("R2 code 11 falling", IDLE_OUT);
        bus_stat = 2'b00; step(); chk("R2 code 00 rising", IDLE_OUT);
        step(); chk("R2 code 00 falling", IDLE_OUT);

        // R2: a read code present only at a falling edge is ignored
        bus_stat = 2'b11; step(); chk("R2 idle rising", IDLE_OUT);
        bus_stat = 2'b01; step(); chk("R2 code on falling", IDLE_OUT);
        bus_stat = 2'b11; step(); chk("R2 no late start", IDLE_OUT);
        step(); chk("R2 still idle", IDLE_OUT);

        // R1: reset in the middle of a write command
        bus_stat = 2'b10; late_cmd = 1'b0; cmd_hold = 1'b0; rdy_n = 1'b1;
        step(); chk("R2 write start", 4'b1111);
        bus_stat = 2'b11;
        step(); chk("R5 write command", 4'b1001);
        rst = 1'b1;
        step(); chk("R1 reset mid cycle", IDLE_OUT);
        rst = 1'b0;
        cmd_hold = 1'b1;

        // R1 and R11: the first edge after reset is rising, so a cycle starts at once
        run_vec(1'b0, 1'b1, 1, 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule